// File: doc/BRIEF.md
# Reference Mode Controller for a Line-Card Clock Synchronizer

This block decides how one digital PLL channel of a line-card timing circuit behaves at any moment. It watches one qualification flag for each candidate reference, the lock indication from the loop, and a two-bit manual override. From these it holds the channel in one of four modes: free-run on the local oscillator, acquiring lock, locked (normal), or holdover. It also reports which reference the loop must track and the frequency control word the synthesizer should use.

While the loop is locked, the block keeps a running average of the loop's frequency word. When every reference disappears, that average becomes the output word, so the channel keeps its last good frequency. If not enough history has been collected, the channel falls back to free-run. Software can pin the mode with the override field. Returning the field to automatic resumes the sequencing from whichever mode was forced.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (free-run), sel_ref_o is 0, hold_valid_o is 0 and mode_change_o is 0. Whenever mode_o is 0, freq_word_o equals the NOMINAL parameter.
- R2: With manual_mode 0 (automatic), a free-run channel that sees any ref_qual bit set moves to mode 1 (acquiring) on the next clock edge.
- R3: Whenever a reference is selected, the choice is the lowest-index set bit of ref_qual. This applies on entry to acquisition and on any reselection.
- R4: In mode 1, if the selected reference is still qualified and loop_locked is 1, the next mode is 2 (normal). In modes 1 and 2, freq_word_o follows loop_freq.
- R5: In mode 1 or 2, if the selected reference loses its qualified bit while another bit of ref_qual is set, the lowest such reference is selected and the mode becomes (or stays) 1.
- R6: In mode 1 or 2, if the selected reference fails and no ref_qual bit is set, the mode becomes 3 (holdover) when hold_valid_o is 1. In holdover with valid history, freq_word_o equals the stored average.
- R7: The history updates only on edges where the mode is 2 and the selected reference's qualified bit is 1. The first update loads loop_freq directly. Each later update adds (loop_freq - average) arithmetically shifted right by ALPHA_SHIFT. Nothing updates on the edge at which the qualified bit is low.
- R8: In holdover, with automatic control, any set ref_qual bit moves the channel to mode 1 on the next edge, selecting per R3.
- R9: mode_change_o is 1 for exactly the cycle in which mode_o shows a value different from its value in the previous cycle, and 0 otherwise.
- R10: hold_valid_o becomes 1 once HIST_MIN updates have occurred and stays 1 until reset. A failure that would enter holdover while hold_valid_o is 0 enters mode 0 instead.
- R11: manual_mode 1, 2 or 3 forces mode 0, 3 or 2 respectively from the next edge. In forced holdover, freq_word_o is NOMINAL when hold_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_qual | input | NUM_REF | One qualified flag per reference |
| loop_locked | input | 1 | Loop reports phase lock on the selected reference |
| loop_freq | input | FREQ_W | Current loop frequency control word |
| manual_mode | input | 2 | 0 auto, 1 force free-run, 2 force holdover, 3 force normal |
| mode_o | output | 2 | 0 free-run, 1 acquiring, 2 normal, 3 holdover |
| sel_ref_o | output | SEL_W | Index of the selected reference |
| freq_word_o | output | FREQ_W | Frequency word for the synthesizer |
| hold_valid_o | output | 1 | Enough history has been captured for holdover |
| mode_change_o | output | 1 | One-cycle pulse on each mode change |

## Verification
On every cycle, the checker confirms several properties. The change strobe must match mode changes exactly. Free-run must output the nominal word. Automatic entry into normal must follow a lock indication. Automatic entry into acquisition must land on a reference that was qualified. Automatic holdover must only be entered with valid history, and that validity must never drop. Only the directed scenarios can show the numerical results. These include the average after a run of samples, the freeze on the failing edge, priority among several qualified references, and the forced-mode outputs.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_ACQ    = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_HOLD   = 2'd3
    } sync_mode_e;

    typedef enum logic [1:0] {
        MAN_AUTO   = 2'd0,
        MAN_FREE   = 2'd1,
        MAN_HOLD   = 2'd2,
        MAN_NORMAL = 2'd3
    } man_mode_e;

    // Decision taken by the sequencing logic for the next edge
    typedef struct packed {
        sync_mode_e mode;
        logic       reselect;
    } step_t;

    function automatic sync_mode_e forced_mode(input man_mode_e m);
        case (m)
            MAN_FREE:   return MODE_FREE;
            MAN_HOLD:   return MODE_HOLD;
            default:    return MODE_NORMAL;
        endcase
    endfunction

    // Where a channel goes when every reference is gone
    function automatic sync_mode_e loss_target(input logic hist_ok);
        return hist_ok ? MODE_HOLD : MODE_FREE;
    endfunction

endpackage

// File: rtl/sync_ref_pick.sv
module sync_ref_pick #(
    parameter int NUM_REF = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_REF-1:0] qual,
    output logic               any_o,
    output logic [SEL_W-1:0]   idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NUM_REF - 1; i >= 0; i--) begin
            if (qual[i]) idx_o = SEL_W'(i);
        end
    end

    assign any_o = |qual;
endmodule

// File: rtl/sync_hold_hist.sv
module sync_hold_hist #(
    parameter int              FREQ_W      = 16,
    parameter int              ALPHA_SHIFT = 3,
    parameter int              HIST_MIN    = 8,
    parameter logic [FREQ_W-1:0] NOMINAL   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [FREQ_W-1:0] sample,
    output logic [FREQ_W-1:0] avg_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(HIST_MIN + 1);

    logic [FREQ_W-1:0]       avg_q;
    logic [CNT_W-1:0]        cnt_q;
    logic signed [FREQ_W:0]  diff;
    logic signed [FREQ_W:0]  step;
    logic [FREQ_W-1:0]       avg_d;

    always_comb begin
        diff  = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
        step  = diff >>> ALPHA_SHIFT;
        if (cnt_q == '0) avg_d = sample;
        else             avg_d = avg_q + step[FREQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            avg_q <= NOMINAL;
            cnt_q <= '0;
        end else if (upd_en) begin
            avg_q <= avg_d;
            if (cnt_q != CNT_W'(HIST_MIN)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign avg_o   = avg_q;
    assign valid_o = (cnt_q == CNT_W'(HIST_MIN));
endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
    import sync_mode_pkg::*;
#(
    parameter int NUM_REF = 4,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  man_mode_e          manual,
    input  logic [NUM_REF-1:0] qual,
    input  logic               locked,
    input  logic               hist_ok,
    input  logic               pick_any,
    input  logic [SEL_W-1:0]   pick_idx,
    output sync_mode_e         mode_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               change_o
);
    sync_mode_e       mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             chg_q;
    logic             sel_ok;
    step_t            nxt;

    assign sel_ok = qual[sel_q];

    always_comb begin
        nxt.mode     = mode_q;
        nxt.reselect = 1'b0;
        if (manual != MAN_AUTO) begin
            nxt.mode = forced_mode(manual);
        end else begin
            case (mode_q)
                MODE_FREE, MODE_HOLD: begin
                    if (pick_any) begin
                        nxt.mode     = MODE_ACQ;
                        nxt.reselect = 1'b1;
                    end
                end
                MODE_ACQ, MODE_NORMAL: begin
                    if (!sel_ok) begin
                        if (pick_any) begin
                            nxt.mode     = MODE_ACQ;
                            nxt.reselect = 1'b1;
                        end else begin
                            nxt.mode = loss_target(hist_ok);
                        end
                    end else if (mode_q == MODE_ACQ && locked) begin
                        nxt.mode = MODE_NORMAL;
                    end
                end
                default: nxt.mode = MODE_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FREE;
            sel_q  <= '0;
            chg_q  <= 1'b0;
        end else begin
            mode_q <= nxt.mode;
            chg_q  <= (nxt.mode != mode_q);
            if (nxt.reselect) sel_q <= pick_idx;
        end
    end

    assign mode_o   = mode_q;
    assign sel_o    = sel_q;
    assign change_o = chg_q;
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int                NUM_REF     = 4,
    parameter int                FREQ_W      = 16,
    parameter int                ALPHA_SHIFT = 3,
    parameter int                HIST_MIN    = 8,
    parameter logic [FREQ_W-1:0] NOMINAL     = 16'h8000,
    localparam int               SEL_W       = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REF-1:0] ref_qual,
    input  logic               loop_locked,
    input  logic [FREQ_W-1:0]  loop_freq,
    input  logic [1:0]         manual_mode,
    output logic [1:0]         mode_o,
    output logic [SEL_W-1:0]   sel_ref_o,
    output logic [FREQ_W-1:0]  freq_word_o,
    output logic               hold_valid_o,
    output logic               mode_change_o
);
    logic             pick_any;
    logic [SEL_W-1:0] pick_idx;
    sync_mode_e       mode_s;
    logic [SEL_W-1:0] sel_s;
    logic             hist_ok;
    logic [FREQ_W-1:0] hist_avg;
    logic             upd_en;

    sync_ref_pick #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_pick (
        .qual  (ref_qual),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    sync_mode_fsm #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .manual   (man_mode_e'(manual_mode)),
        .qual     (ref_qual),
        .locked   (loop_locked),
        .hist_ok  (hist_ok),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .mode_o   (mode_s),
        .sel_o    (sel_s),
        .change_o (mode_change_o)
    );

    // History is fed only while locked and the tracked reference is still good
    assign upd_en = (mode_s == MODE_NORMAL) && ref_qual[sel_s];

    sync_hold_hist #(
        .FREQ_W(FREQ_W), .ALPHA_SHIFT(ALPHA_SHIFT),
        .HIST_MIN(HIST_MIN), .NOMINAL(NOMINAL)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (upd_en),
        .sample  (loop_freq),
        .avg_o   (hist_avg),
        .valid_o (hist_ok)
    );

    always_comb begin
        case (mode_s)
            MODE_ACQ, MODE_NORMAL: freq_word_o = loop_freq;
            MODE_HOLD:             freq_word_o = hist_ok ? hist_avg : NOMINAL;
            default:               freq_word_o = NOMINAL;
        endcase
    end

    assign mode_o       = mode_s;
    assign sel_ref_o    = sel_s;
    assign hold_valid_o = hist_ok;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk #(
    parameter int                NUM_REF = 4,
    parameter int                FREQ_W  = 16,
    parameter int                SEL_W   = 2,
    parameter logic [FREQ_W-1:0] NOMINAL = 16'h8000
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REF-1:0] ref_qual,
    input logic               loop_locked,
    input logic [1:0]         manual_mode,
    input logic [1:0]         mode_o,
    input logic [SEL_W-1:0]   sel_ref_o,
    input logic [FREQ_W-1:0]  freq_word_o,
    input logic               hold_valid_o,
    input logic               mode_change_o
);
    logic [NUM_REF-1:0] qual_prev;
    always_ff @(posedge clk) qual_prev <= ref_qual;

    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> mode_change_o); // R9
    AST_STROBE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (rst)
        mode_change_o |-> (mode_o != $past(mode_o))); // R9
    AST_FREE_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> (freq_word_o == NOMINAL)); // R1
    AST_NORMAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 2'd1 && mode_o == 2'd2 && $past(manual_mode) == 2'd0)
        |-> $past(loop_locked)); // R4
    AST_ACQ_ON_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) != 2'd1 && mode_o == 2'd1 && $past(manual_mode) == 2'd0)
        |-> qual_prev[sel_ref_o]); // R3
    AST_HOLD_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) != 2'd3 && mode_o == 2'd3 && $past(manual_mode) == 2'd0)
        |-> hold_valid_o); // R10
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        hold_valid_o |=> hold_valid_o); // R10
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk #(
    .NUM_REF(NUM_REF), .FREQ_W(FREQ_W), .SEL_W(SEL_W), .NOMINAL(NOMINAL)
) u_chk (
    .clk(clk), .rst(rst), .ref_qual(ref_qual), .loop_locked(loop_locked),
    .manual_mode(manual_mode), .mode_o(mode_o), .sel_ref_o(sel_ref_o),
    .freq_word_o(freq_word_o), .hold_valid_o(hold_valid_o),
    .mode_change_o(mode_change_o)
);

// File: tb/sync_mode_ctrl_tb.sv
module sync_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ALPHA      = 3;
    localparam logic [15:0] NOM = 16'h8000;
    localparam logic [15:0] F1  = 16'h8100;
    localparam logic [15:0] F2  = 16'h8300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ref_qual = '0;
    logic        loop_locked = 1'b0;
    logic [15:0] loop_freq = F1;
    logic [1:0]  manual_mode = 2'd0;
    logic [1:0]  mode_o;
    logic [1:0]  sel_ref_o;
    logic [15:0] freq_word_o;
    logic        hold_valid_o;
    logic        mode_change_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_avg;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_mode_ctrl #(.ALPHA_SHIFT(ALPHA), .HIST_MIN(8), .NOMINAL(NOM)) u_dut (
        .clk(clk), .rst(rst), .ref_qual(ref_qual), .loop_locked(loop_locked),
        .loop_freq(loop_freq), .manual_mode(manual_mode), .mode_o(mode_o),
        .sel_ref_o(sel_ref_o), .freq_word_o(freq_word_o),
        .hold_valid_o(hold_valid_o), .mode_change_o(mode_change_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_qual = '0; loop_locked = 1'b0; manual_mode = 2'd0;
        loop_freq = F1;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 sel", sel_ref_o, 0);
        chk("R1 freq", freq_word_o, NOM);
        chk("R1 valid", hold_valid_o, 0);
        chk("R1 strobe", mode_change_o, 0);
    endtask

    task automatic t_acquire();
        ref_qual = 4'b1100;
        step(1);
        chk("R2 mode", mode_o, 1);
        chk("R3 sel", sel_ref_o, 2);
        chk("R9 strobe high", mode_change_o, 1);
        step(1);
        chk("R9 strobe low", mode_change_o, 0);
        chk("R4 stays acq unlocked", mode_o, 1);
        chk("R4 freq follows loop", freq_word_o, F1);
    endtask

    task automatic t_lock_history();
        loop_locked = 1'b1;
        step(1);
        chk("R4 normal", mode_o, 2);
        step(7);
        chk("R10 valid after 7", hold_valid_o, 0);
        step(1);
        chk("R10 valid after 8", hold_valid_o, 1);
        step(2);
        exp_avg = F1;
        loop_freq = F2;
        step(2);
        for (int k = 0; k < 2; k++) exp_avg = exp_avg + ((int'(F2) - exp_avg) >>> ALPHA);
        chk("R4 freq normal", freq_word_o, F2);
    endtask

    task automatic t_failover();
        ref_qual = 4'b1000;
        loop_locked = 1'b0;
        step(1);
        chk("R5 mode", mode_o, 1);
        chk("R5 sel", sel_ref_o, 3);
        loop_locked = 1'b1;
        step(1);
        chk("R4 relock", mode_o, 2);
        ref_qual = 4'b0000;
        loop_freq = 16'h1234;
        step(1);
        chk("R6 hold", mode_o, 3);
        chk("R7 hold word frozen", freq_word_o, exp_avg);
    endtask

    task automatic t_reacquire();
        loop_locked = 1'b0;
        ref_qual = 4'b0110;
        step(1);
        chk("R8 mode", mode_o, 1);
        chk("R8 sel", sel_ref_o, 1);
    endtask

    task automatic t_manual();
        manual_mode = 2'd2;
        step(1);
        chk("R11 forced hold", mode_o, 3);
        chk("R11 forced hold word", freq_word_o, exp_avg);
        manual_mode = 2'd1;
        step(1);
        chk("R11 forced free", mode_o, 0);
        chk("R11 forced free word", freq_word_o, NOM);
        manual_mode = 2'd3;
        step(1);
        chk("R11 forced normal", mode_o, 2);
        chk("R9 strobe forced", mode_change_o, 1);
    endtask

    task automatic t_fallback();
        do_reset();
        ref_qual = 4'b0001;
        step(1);
        loop_locked = 1'b1;
        step(1);
        chk("R4 normal short", mode_o, 2);
        step(2);
        ref_qual = 4'b0000;
        step(1);
        chk("R10 fallback free", mode_o, 0);
        chk("R10 fallback word", freq_word_o, NOM);
        manual_mode = 2'd2;
        step(1);
        chk("R11 hold no history", mode_o, 3);
        chk("R11 hold nominal", freq_word_o, NOM);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_acquire();
        t_lock_history();
        t_failover();
        t_reacquire();
        t_manual();
        t_fallback();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule